// File: doc/BRIEF.md
# Synchronous Character Sync and DLE Detector

This block sits behind the character assembler of a synchronous receiver. It looks at each whole character the assembler hands over. From the stream it decides when character synchronization has been gained, and it keeps two sticky status flags:
- a sync-detect flag, raised by the programmed sync pattern and, in transparent mode, by a DLE-SYN1 escape;
- a DLE-detect flag, raised when a DLE character arrives in transparent mode with parity off.

Bit alignment and hunting happen upstream. This block only sees one strobe per completed character.

The sync pattern is a single SYN1 character or a SYN1 followed by SYN2, picked by a mode input. In non-transparent mode the pattern keeps raising the sync flag for as long as it appears. In transparent mode the pattern only counts until sync is gained. After that, only a DLE immediately followed by SYN1 raises the flag. A doubled DLE is treated as literal data. Software clears the flags with a status-read strobe (sync flag) and a reset-error strobe (DLE flag). Turning the receiver off clears everything.

Top module: `sync_char_detect`

## Requirements
- R1: After reset is asserted, `sync_o`, `dle_det_o` and `syn_det_o` are all 0.
- R2: In non-transparent, single-SYN mode, a valid character equal to `syn1_i` sets `syn_det_o` and `sync_o` at the clock edge that samples the strobe. Any other character sets neither.
- R3: In double-SYN mode the pattern is SYN1 on one valid character and SYN2 on the very next valid character. A character other than SYN2 after SYN1 restarts the search. A SYN1 in the second position becomes a new first SYN1.
- R4: In non-transparent mode the sync pattern keeps setting `syn_det_o` after `sync_o` is already 1.
- R5: In transparent mode the sync pattern sets `syn_det_o` only while `sync_o` is 0. Once `sync_o` is 1, only a DLE followed on the next valid character by SYN1 sets it. Any other character in between breaks the pair.
- R6: `dle_det_o` is set by a valid DLE character only when `transparent_i`=1 and `parity_en_i`=0.
- R7: Of two consecutive DLE characters only the first sets `dle_det_o`. The second is consumed as data and does not start a DLE-SYN1 pair. A third consecutive DLE counts as a new first DLE.
- R8: `status_rd_i` clears `syn_det_o` on the next edge. A set in the same cycle wins over the clear.
- R9: `reset_err_i` clears `dle_det_o` on the next edge and leaves `syn_det_o` unchanged. A set in the same cycle wins over the clear.
- R10: While `rx_en_i`=0, all three outputs and all pairing state are cleared, and character strobes are ignored. After re-enabling, sync must be gained again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | One-cycle strobe: a new character is on `char_i` |
| char_i | input | W | Received character |
| syn1_i | input | W | First sync character |
| syn2_i | input | W | Second sync character |
| dle_i | input | W | DLE character |
| double_syn_i | input | 1 | 1: SYN1-SYN2 pattern; 0: SYN1 alone |
| transparent_i | input | 1 | Transparent mode select |
| parity_en_i | input | 1 | Parity enabled (suppresses DLE flagging) |
| rx_en_i | input | 1 | Receiver enable |
| status_rd_i | input | 1 | Status read strobe, clears sync-detect flag |
| reset_err_i | input | 1 | Reset-error strobe, clears DLE-detect flag |
| sync_o | output | 1 | Character sync achieved |
| dle_det_o | output | 1 | DLE-detect status flag |
| syn_det_o | output | 1 | Sync-detect status flag |

## Verification
The bench aims at the sequence corners.
- A SYN1 repeated in the second slot of a double-SYN search: a design that drops it instead of restarting would miss the following SYN2.
- A SYN2 that follows a non-SYN1 character: a design that is too eager would falsely acquire sync there.
- Triple DLE runs, and a doubled DLE followed by SYN1: a pending state that is not consumed would flag the second DLE or raise sync detect on literal data.
- A set arriving in the same cycle as its clear strobe, and a bare sync pattern in transparent mode after sync: these expose a design that loses events or re-signals sync on the wrong sequence.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  typedef struct packed {
    logic syn1;
    logic syn2;
    logic dle;
  } char_hits_t;
endpackage

// File: rtl/char_match.sv
module char_match
  import sync_det_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] char_i,
  input  logic [W-1:0] syn1_i,
  input  logic [W-1:0] syn2_i,
  input  logic [W-1:0] dle_i,
  output char_hits_t   hits_o
);
  always_comb begin
    hits_o.syn1 = (char_i == syn1_i);
    hits_o.syn2 = (char_i == syn2_i);
    hits_o.dle  = (char_i == dle_i);
  end
endmodule

// File: rtl/syn_seq.sv
module syn_seq
  import sync_det_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       valid_i,
  input  char_hits_t hits_i,
  input  logic       double_syn_i,
  output logic       pat_hit_o,
  output logic       sync_o
);
  logic first_q;
  logic sync_q;

  always_comb begin
    if (double_syn_i) pat_hit_o = valid_i && first_q && hits_i.syn2;
    else              pat_hit_o = valid_i && hits_i.syn1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (!en_i) begin
      first_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (valid_i) begin
      // mismatch restarts; SYN1 in second slot becomes a new first
      first_q <= double_syn_i && hits_i.syn1 && !pat_hit_o;
      sync_q  <= sync_q | pat_hit_o;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/dle_track.sv
module dle_track
  import sync_det_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       valid_i,
  input  char_hits_t hits_i,
  input  logic       transparent_i,
  input  logic       parity_en_i,
  input  logic       sync_i,
  output logic       dle_set_o,
  output logic       dle_syn_hit_o
);
  logic pend_q;
  logic dle_first;

  // pending DLE consumes the next DLE of a pair
  assign dle_first     = valid_i && transparent_i && hits_i.dle && !pend_q;
  assign dle_set_o     = dle_first && !parity_en_i;
  assign dle_syn_hit_o = valid_i && transparent_i && sync_i && pend_q && hits_i.syn1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!en_i)    pend_q <= 1'b0;
    else if (valid_i)  pend_q <= dle_first;
  end
endmodule

// File: rtl/sync_char_detect.sv
module sync_char_detect
  import sync_det_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         char_valid_i,
  input  logic [W-1:0] char_i,
  input  logic [W-1:0] syn1_i,
  input  logic [W-1:0] syn2_i,
  input  logic [W-1:0] dle_i,
  input  logic         double_syn_i,
  input  logic         transparent_i,
  input  logic         parity_en_i,
  input  logic         rx_en_i,
  input  logic         status_rd_i,
  input  logic         reset_err_i,
  output logic         sync_o,
  output logic         dle_det_o,
  output logic         syn_det_o
);
  char_hits_t hits;
  logic       valid;
  logic       pat_hit;
  logic       sync_q;
  logic       dle_set;
  logic       dle_syn_hit;
  logic       syn_set;
  logic       dle_det_q;
  logic       syn_det_q;

  assign valid = char_valid_i && rx_en_i;

  char_match #(.W(W)) u_match (
    .char_i (char_i),
    .syn1_i (syn1_i),
    .syn2_i (syn2_i),
    .dle_i  (dle_i),
    .hits_o (hits)
  );

  syn_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (rx_en_i),
    .valid_i      (valid),
    .hits_i       (hits),
    .double_syn_i (double_syn_i),
    .pat_hit_o    (pat_hit),
    .sync_o       (sync_q)
  );

  dle_track u_dle (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (rx_en_i),
    .valid_i       (valid),
    .hits_i        (hits),
    .transparent_i (transparent_i),
    .parity_en_i   (parity_en_i),
    .sync_i        (sync_q),
    .dle_set_o     (dle_set),
    .dle_syn_hit_o (dle_syn_hit)
  );

  // transparent mode: plain pattern counts only before sync is held
  assign syn_set = (pat_hit && !(transparent_i && sync_q)) || dle_syn_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dle_det_q <= 1'b0;
      syn_det_q <= 1'b0;
    end else if (!rx_en_i) begin
      dle_det_q <= 1'b0;
      syn_det_q <= 1'b0;
    end else begin
      if (dle_set)          dle_det_q <= 1'b1;
      else if (reset_err_i) dle_det_q <= 1'b0;
      if (syn_set)          syn_det_q <= 1'b1;
      else if (status_rd_i) syn_det_q <= 1'b0;
    end
  end

  assign sync_o    = sync_q;
  assign dle_det_o = dle_det_q;
  assign syn_det_o = syn_det_q;
endmodule

// File: rtl/sync_char_detect_chk.sv
module sync_char_detect_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         char_valid_i,
  input logic [W-1:0] char_i,
  input logic         transparent_i,
  input logic         parity_en_i,
  input logic         rx_en_i,
  input logic         status_rd_i,
  input logic         reset_err_i,
  input logic         sync_o,
  input logic         dle_det_o,
  input logic         syn_det_o
);
  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!sync_o && !dle_det_o && !syn_det_o));

  a_r8_read_clears_syn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !char_valid_i) |=> !syn_det_o);

  a_r9_reset_err_clears_dle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_err_i && !char_valid_i) |=> !dle_det_o);

  a_r6_dle_needs_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dle_det_o) |-> $past(char_valid_i && rx_en_i && transparent_i && !parity_en_i));

  a_r2_syn_needs_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(syn_det_o) |-> $past(char_valid_i && rx_en_i));

  a_r3_sync_rises_with_syn_det: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> syn_det_o);

  a_r10_sync_drops_only_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> $past(!rx_en_i));
endmodule

bind sync_char_detect sync_char_detect_chk #(.W(W)) u_chk (.*);

// File: tb/sync_char_detect_test.sv
module sync_char_detect_test;
  localparam int W = 8;
  localparam logic [W-1:0] S1 = 8'h16, S2 = 8'h17, DL = 8'h10, XX = 8'h41;

  typedef struct {
    logic  s;
    logic  d;
    logic  y;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic v = 1'b0, dbl = 1'b0, tr = 1'b0, par = 1'b0, en = 1'b0, rd = 1'b0, rerr = 1'b0;
  logic [W-1:0] c = '0;
  logic sync_o, dle_det_o, syn_det_o;
  int n_cmp = 0, n_bad = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  sync_char_detect #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(v), .char_i(c),
    .syn1_i(S1), .syn2_i(S2), .dle_i(DL), .double_syn_i(dbl),
    .transparent_i(tr), .parity_en_i(par), .rx_en_i(en),
    .status_rd_i(rd), .reset_err_i(rerr),
    .sync_o(sync_o), .dle_det_o(dle_det_o), .syn_det_o(syn_det_o)
  );

  task automatic cmp(input exp_t e);
    n_cmp++;
    if (sync_o !== e.s || dle_det_o !== e.d || syn_det_o !== e.y) begin
      n_bad++;
      $display("FAIL %s: got sync/dle/syn=%b%b%b exp %b%b%b",
               e.tag, sync_o, dle_det_o, syn_det_o, e.s, e.d, e.y);
    end
  endtask

  // monitor: pops one expectation per cycle
  always @(negedge clk) if (q.size() > 0) cmp(q.pop_front());

  task automatic step(input logic vv, input logic [W-1:0] cc, input logic r,
                      input logic re, input logic es, input logic ed,
                      input logic ey, input string tag);
    exp_t e;
    @(negedge clk);
    v = vv; c = cc; rd = r; rerr = re;
    @(posedge clk); #1;
    v = 1'b0; rd = 1'b0; rerr = 1'b0;
    e.s = es; e.d = ed; e.y = ey; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic ch(input logic [W-1:0] cc, input logic es, input logic ed,
                    input logic ey, input string tag);
    step(1'b1, cc, 1'b0, 1'b0, es, ed, ey, tag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    #1;
    e0.s = 0; e0.d = 0; e0.y = 0; e0.tag = "R1 reset";
    cmp(e0);
    rst_n = 1'b1;
    en = 1'b1;
    step(0, XX, 0, 0, 0, 0, 0, "R1 idle");
    // non-transparent single SYN
    ch(XX, 0, 0, 0, "R2 non-syn char");
    ch(S1, 1, 0, 1, "R2 syn1 acquires");
    step(0, XX, 1, 0, 1, 0, 0, "R8 read clears");
    ch(S1, 1, 0, 1, "R4 pattern again");
    step(1, S1, 1, 0, 1, 0, 1, "R8 set wins over read");
    step(0, XX, 1, 0, 1, 0, 0, "R8 read clears again");
    ch(DL, 1, 0, 0, "R6 dle non-transparent");
    en = 1'b0;
    step(0, XX, 0, 0, 0, 0, 0, "R10 disable clears");
    ch(S1, 0, 0, 0, "R10 char ignored while off");
    // non-transparent double SYN
    en = 1'b1; dbl = 1'b1;
    ch(S1, 0, 0, 0, "R3 first syn1");
    ch(XX, 0, 0, 0, "R3 mismatch");
    ch(S2, 0, 0, 0, "R3 syn2 without syn1");
    ch(S1, 0, 0, 0, "R3 syn1");
    ch(S1, 0, 0, 0, "R3 syn1 in second slot");
    ch(S2, 1, 0, 1, "R3 pair completes");
    step(0, XX, 1, 0, 1, 0, 0, "R8 read");
    ch(S1, 1, 0, 0, "R4 syn1");
    ch(S2, 1, 0, 1, "R4 pair after sync");
    en = 1'b0;
    step(0, XX, 0, 0, 0, 0, 0, "R10 disable");
    // transparent single SYN
    en = 1'b1; dbl = 1'b0; tr = 1'b1;
    ch(DL, 0, 1, 0, "R6 dle flagged");
    ch(DL, 0, 1, 0, "R7 second dle consumed");
    step(0, XX, 0, 1, 0, 0, 0, "R9 reset error clears");
    ch(DL, 0, 1, 0, "R7 third dle is new first");
    step(0, XX, 0, 1, 0, 0, 0, "R9 reset error");
    ch(S1, 1, 0, 1, "R5 initial sync");
    step(0, XX, 1, 0, 1, 0, 0, "R8 read");
    ch(S1, 1, 0, 0, "R5 bare syn1 after sync");
    ch(DL, 1, 1, 0, "R6 dle");
    ch(S1, 1, 1, 1, "R5 dle-syn1");
    step(0, XX, 0, 1, 1, 0, 1, "R9 reset error keeps syn");
    step(0, XX, 1, 0, 1, 0, 0, "R8 read");
    ch(DL, 1, 1, 0, "R5 dle");
    ch(XX, 1, 1, 0, "R5 break");
    ch(S1, 1, 1, 0, "R5 broken pair");
    ch(DL, 1, 1, 0, "R7 dle");
    ch(DL, 1, 1, 0, "R7 dle consumed");
    ch(S1, 1, 1, 0, "R7 doubled dle not escape");
    step(0, XX, 0, 1, 1, 0, 0, "R9 reset error");
    par = 1'b1;
    ch(DL, 1, 0, 0, "R6 parity on no flag");
    ch(XX, 1, 0, 0, "R6 data");
    par = 1'b0;
    step(1, DL, 0, 1, 1, 1, 0, "R9 set wins over reset error");
    en = 1'b0;
    step(0, XX, 0, 0, 0, 0, 0, "R10 disable");
    en = 1'b1;
    ch(S1, 1, 0, 1, "R10 reacquire");
    // transparent double SYN
    en = 1'b0;
    step(0, XX, 0, 0, 0, 0, 0, "R10 disable");
    en = 1'b1; dbl = 1'b1;
    ch(S1, 0, 0, 0, "R5 syn1");
    ch(S2, 1, 0, 1, "R5 initial pair");
    step(0, XX, 1, 0, 1, 0, 0, "R8 read");
    ch(S1, 1, 0, 0, "R5 syn1 after sync");
    ch(S2, 1, 0, 0, "R5 bare pair ignored");
    ch(DL, 1, 1, 0, "R6 dle");
    ch(S1, 1, 1, 1, "R5 dle-syn1 in double mode");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule